// File: doc/BRIEF.md
# MLT-3 Quadrature Line Serializer

This block takes framed words in parallel over a valid/ready handshake and sends them to the line one baud at a time. Each baud is marked by a single-cycle baud-enable strobe. The wide word crosses in the slow parallel domain, and serialization is the last stage before the line drivers. One word can wait in a holding buffer while the previous word is still shifting. This lets consecutive words go out with no idle baud between them.

Line coding is MLT-3. The line level walks around the four-step cycle 0, +1, 0, -1. A 1 bit moves it one step and a 0 bit leaves it where it is. The cycle position is held in a reversible 2-bit Gray (quadrature) counter. The two counter bits drive the two transformer halves directly as two signals a quarter cycle apart, so the halves never oppose each other. A per-word invert flag reverses the counting direction, which flips the polarity of that whole word on the line. A signed ternary level output is provided for checking.

Top module: `mlt3_quad_serializer`

## Requirements
- R1: Reset is synchronous. While `rst` is high, `wordReady` is low. After reset the counter state is 00, both drive outputs are low, `lineLevel` is 0, and no word is held.
- R2: A word and its invert flag are captured only on a cycle where `wordValid` and `wordReady` are both high. `wordReady` stays low while a captured word has not yet started shifting, so at most one word waits and none is overwritten.
- R3: Exactly one bit is consumed per cycle with `baudEn` high, most significant bit first. On a cycle with `baudEn` low the drive outputs do not change.
- R4: Each consumed 1 bit moves the counter exactly one step. Each consumed 0 bit leaves it unchanged. The outputs change on the clock edge that samples the strobe.
- R5: With the invert flag 0, the counter state {lineDriveB, lineDriveA} steps 00 → 01 → 11 → 10 → 00.
- R6: With the invert flag 1, the counter state steps 00 → 10 → 11 → 01 → 00.
- R7: The invert flag is taken from the word when the word starts. Changes on `wordInvert` at any other time do not affect the word being sent.
- R8: If a word is waiting when the last bit of the current word is consumed, its MSB is consumed on the very next strobe, leaving no idle baud.
- R9: A strobe that arrives with no bit left and no word waiting consumes nothing and leaves the outputs unchanged. A word that arrives later starts on the first strobe after it is captured.
- R10: `lineLevel` is the 2-bit two's-complement value lineDriveA − lineDriveB: 00 for 0, 01 for +1, 11 for −1. The value 10 never appears.
- R11: Take p as the count of 1s in a word and d as the number of forward steps the word moves the counter, modulo 4. Then d equals p mod 4 with the invert flag 0, and (4 − p mod 4) mod 4 with the flag 1. A word with p a multiple of 4 therefore ends in its starting state, and one with p even ends in the same or the opposite state.
- R12: Between any two consecutive clock cycles at most one of the two drive outputs changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wordValid | input | 1 | Word offered on `wordData` |
| wordData | input | WORD_W | Framed word, sent MSB first |
| wordInvert | input | 1 | Reverse counting direction for this word |
| wordReady | output | 1 | Holding buffer can accept a word |
| baudEn | input | 1 | One-cycle strobe per line baud |
| lineDriveA | output | 1 | Quadrature counter bit 0, drive for one transformer half |
| lineDriveB | output | 1 | Quadrature counter bit 1, drive for the other half |
| lineLevel | output | 2 | Signed ternary line level (+1, 0, −1) |

## Verification
The hardest case to reach from the ports is a word boundary that happens at the same time as a handshake and a direction change. A waiting word with the opposite invert flag must take over on the strobe right after the last bit. During the same period the handshake must refill the holding buffer. Also, a toggling `wordInvert` must not disturb the word already on the line. The stimulus gets there by streaming a sweep of 2048 words back to back with the flag alternating by pattern, and then by random valid, strobe and invert traffic. Throughout, a reference model computes the counter phase arithmetically, and the phase reached at the end of every word is checked against the word's count of 1s.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;

  // Strobes from control to the datapath, one cycle each
  typedef struct packed {
    logic capture;   // latch the offered word into the holding buffer
    logic load;      // move the held word into the shifter and emit its MSB
    logic shift;     // emit the next bit of the word in the shifter
  } serStrobe_t;

  // Quadrature state encoding {driveB, driveA}
  localparam logic [1:0] QUAD_NEUTRAL_LO = 2'b00;
  localparam logic [1:0] QUAD_POSITIVE   = 2'b01;
  localparam logic [1:0] QUAD_NEUTRAL_HI = 2'b11;
  localparam logic [1:0] QUAD_NEGATIVE   = 2'b10;

endpackage

// File: rtl/mlt3_quad_counter.sv
module mlt3_quad_counter
  import mlt3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stepEn,
  input  logic       stepRev,
  output logic [1:0] qState
);

  logic [1:0] qNext;
  logic       rstSeen;

  // Gray stepping: forward 00,01,11,10 ; reverse 00,10,11,01
  always_comb begin
    qNext = qState;
    if (stepEn) begin
      if (stepRev) qNext = {~qState[0], qState[1]};
      else         qNext = {qState[0], ~qState[1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) qState <= QUAD_NEUTRAL_LO;
    else     qState <= qNext;
  end

  always_ff @(posedge clk) rstSeen <= rst;

  p_reset_neutral_r1: assert property (@(posedge clk)
    rstSeen |-> qState == QUAD_NEUTRAL_LO);

  p_step_moves_r4: assert property (@(posedge clk) disable iff (rst)
    stepEn |=> qState != $past(qState));

  p_hold_no_step_r4: assert property (@(posedge clk) disable iff (rst)
    !stepEn |=> $stable(qState));

  p_single_flip_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(qState ^ $past(qState)) <= 1);

endmodule

// File: rtl/mlt3_ctrl.sv
module mlt3_ctrl
  import mlt3_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wordValid,
  input  logic       baudEn,
  output logic       wordReady,
  output serStrobe_t ctrlStrobes
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic             bufFull;
  logic [CNT_W-1:0] bitsLeft;
  logic             shifterEmpty;

  assign shifterEmpty = (bitsLeft == '0);
  assign wordReady    = !bufFull && !rst;

  always_comb begin
    ctrlStrobes.capture = wordValid && wordReady;
    ctrlStrobes.load    = baudEn && shifterEmpty && bufFull;
    ctrlStrobes.shift   = baudEn && !shifterEmpty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufFull  <= 1'b0;
      bitsLeft <= '0;
    end else begin
      if (ctrlStrobes.capture)   bufFull <= 1'b1;
      else if (ctrlStrobes.load) bufFull <= 1'b0;

      if (ctrlStrobes.load)       bitsLeft <= LAST_IDX;
      else if (ctrlStrobes.shift) bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  p_no_overwrite_r2: assert property (@(posedge clk) disable iff (rst)
    bufFull && !ctrlStrobes.load |=> bufFull && !wordReady);

  p_capture_fills_r2: assert property (@(posedge clk) disable iff (rst)
    ctrlStrobes.capture |=> bufFull);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    bitsLeft <= LAST_IDX);

  p_gapless_r8: assert property (@(posedge clk) disable iff (rst)
    ctrlStrobes.shift && bitsLeft == CNT_W'(1) && bufFull && baudEn
      |=> shifterEmpty);

endmodule

// File: rtl/mlt3_datapath.sv
module mlt3_datapath
  import mlt3_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordInvert,
  input  serStrobe_t        ctrlStrobes,
  output logic [1:0]        qState
);

  logic [WORD_W-1:0] bufData;
  logic              bufInv;
  logic [WORD_W-1:0] shiftReg;
  logic              wordDir;
  logic              outBit;
  logic              stepEn;
  logic              stepRev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bufData <= '0;
      bufInv  <= 1'b0;
    end else if (ctrlStrobes.capture) begin
      bufData <= wordData;
      bufInv  <= wordInvert;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      wordDir  <= 1'b0;
    end else if (ctrlStrobes.load) begin
      shiftReg <= {bufData[WORD_W-2:0], 1'b0};
      wordDir  <= bufInv;
    end else if (ctrlStrobes.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  always_comb begin
    outBit  = ctrlStrobes.load ? bufData[WORD_W-1] : shiftReg[WORD_W-1];
    stepEn  = (ctrlStrobes.load || ctrlStrobes.shift) && outBit;
    stepRev = ctrlStrobes.load ? bufInv : wordDir;
  end

  mlt3_quad_counter u_counter (
    .clk     (clk),
    .rst     (rst),
    .stepEn  (stepEn),
    .stepRev (stepRev),
    .qState  (qState)
  );

  p_dir_held_r7: assert property (@(posedge clk) disable iff (rst)
    ctrlStrobes.shift |=> $stable(wordDir));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(ctrlStrobes.load || ctrlStrobes.shift) |=> $stable(qState));

endmodule

// File: rtl/mlt3_quad_serializer.sv
module mlt3_quad_serializer
  import mlt3_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordInvert,
  output logic              wordReady,
  input  logic              baudEn,
  output logic              lineDriveA,
  output logic              lineDriveB,
  output logic [1:0]        lineLevel
);

  serStrobe_t ctrlStrobes;
  logic [1:0] qState;

  mlt3_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wordValid   (wordValid),
    .baudEn      (baudEn),
    .wordReady   (wordReady),
    .ctrlStrobes (ctrlStrobes)
  );

  mlt3_datapath #(.WORD_W(WORD_W)) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .wordData    (wordData),
    .wordInvert  (wordInvert),
    .ctrlStrobes (ctrlStrobes),
    .qState      (qState)
  );

  always_comb begin
    lineDriveA = qState[0];
    lineDriveB = qState[1];
    lineLevel  = {1'b0, qState[0]} - {1'b0, qState[1]};
  end

  p_ready_low_reset_r1: assert property (@(posedge clk)
    rst |-> !wordReady);

  p_level_legal_r10: assert property (@(posedge clk) disable iff (rst)
    lineLevel != 2'b10);

  p_strobe_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !baudEn |=> $stable({lineDriveB, lineDriveA}));

endmodule

// File: tb/tb_mlt3_quad_serializer.sv
`timescale 1ns/1ps
module tb_mlt3_quad_serializer;

  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wordValid = 1'b0;
  logic [W-1:0] wordData = '0;
  logic         wordInvert = 1'b0;
  logic         wordReady;
  logic         baudEn = 1'b0;
  logic         lineDriveA, lineDriveB;
  logic [1:0]   lineLevel;

  always #2 clk = ~clk;

  mlt3_quad_serializer #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst), .wordValid(wordValid), .wordData(wordData),
    .wordInvert(wordInvert), .wordReady(wordReady), .baudEn(baudEn),
    .lineDriveA(lineDriveA), .lineDriveB(lineDriveB), .lineLevel(lineLevel)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model
  logic [W-1:0] mBuf, mCur;
  logic         mBufInv, mCurInv, mBufFull;
  int           mLeft, mPh, mStartPh;
  bit           pendR11;
  logic [1:0]   prevState;
  logic [31:0]  lfsr = 32'hACE1_2024;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] phState(input int ph);
    case (ph)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int stateToPh(input logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] phLevel(input int ph);
    if (ph == 1) return 2'b01;
    if (ph == 3) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic modelReset();
    mBuf = '0; mCur = '0; mBufInv = 0; mCurInv = 0; mBufFull = 0;
    mLeft = 0; mPh = 0; mStartPh = 0; pendR11 = 0; prevState = 2'b00;
  endtask

  task automatic cyc(input logic v, input logic [W-1:0] d, input logic inv,
                     input logic be, input string tag);
    logic [1:0] st;
    logic       bitv;
    bit         emit;
    bit         acc;
    @(negedge clk);
    st = {lineDriveB, lineDriveA};
    chk(st == phState(mPh), tag, "drive state {B,A}", st, phState(mPh));
    chk(lineLevel == phLevel(mPh), "R10", "lineLevel", lineLevel, phLevel(mPh));
    chk(wordReady == !mBufFull, tag, "wordReady", wordReady, !mBufFull);
    chk($countones(st ^ prevState) <= 1, "R12", "drive bits flipped",
        $countones(st ^ prevState), 1);
    prevState = st;
    if (pendR11) begin
      int pop = $countones(mCur);
      int dph = (stateToPh(st) - mStartPh + 4) % 4;
      int exp = mCurInv ? (4 - pop % 4) % 4 : pop % 4;
      chk(dph == exp, "R11", "phase moved by word", dph, exp);
      pendR11 = 0;
    end
    wordValid = v; wordData = d; wordInvert = inv; baudEn = be;
    acc = v && !mBufFull;
    emit = 0; bitv = 0;
    if (be) begin
      if (mLeft == 0 && mBufFull) begin
        mCur = mBuf; mCurInv = mBufInv; mBufFull = 0;
        mLeft = W - 1; mStartPh = mPh;
        bitv = mCur[W-1]; emit = 1;
      end else if (mLeft > 0) begin
        mLeft--; bitv = mCur[mLeft]; emit = 1;
        if (mLeft == 0) pendR11 = 1;
      end
    end
    if (emit && bitv) mPh = mCurInv ? (mPh + 3) % 4 : (mPh + 1) % 4;
    if (acc) begin mBuf = d; mBufInv = inv; mBufFull = 1; end
  endtask

  task automatic pushWord(input logic [W-1:0] d, input logic inv,
                          input int per, input string tag);
    int c = 0;
    bit acc;
    do begin
      acc = !mBufFull;
      cyc(1'b1, d, inv, (c % per) == 0, tag);
      c++;
    end while (!acc);
  endtask

  task automatic drain(input int per, input bit toggleInv, input string tag);
    int c = 0;
    while (mLeft != 0 || mBufFull) begin
      cyc(1'b0, '0, toggleInv ? c[0] : 1'b0, (c % per) == 0, tag);
      c++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    modelReset();
    // R1: ready low during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(wordReady == 1'b0, "R1", "wordReady in reset", wordReady, 0);
    end
    rst = 1'b0;
    // R1 reset state, R9 idle strobes consume nothing
    cyc(1'b0, '0, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, 1'b1, "R9");

    // R5 forward stepping, all ones
    pushWord({W{1'b1}}, 1'b0, 1, "R5");
    drain(1, 1'b0, "R5");
    // R6 reverse stepping
    pushWord({W{1'b1}}, 1'b1, 1, "R6");
    drain(1, 1'b0, "R6");
    // R3 sparse strobes, MSB first, hold between strobes
    pushWord(20'hA5C3F, 1'b0, 3, "R3");
    drain(3, 1'b0, "R3");
    pushWord(20'h80001, 1'b1, 4, "R3");
    drain(4, 1'b0, "R3");
    // R4 single one bits at both ends and zeros
    pushWord(20'h00000, 1'b0, 1, "R4");
    pushWord(20'h00001, 1'b0, 1, "R4");
    drain(1, 1'b0, "R4");
    // R7 invert input toggling while a word shifts
    pushWord(20'hF0F0F, 1'b0, 2, "R7");
    drain(2, 1'b1, "R7");
    pushWord(20'h3C3C3, 1'b1, 1, "R7");
    drain(1, 1'b1, "R7");
    // R8 back-to-back words, alternating direction
    pushWord(20'hFFFFF, 1'b0, 1, "R8");
    pushWord(20'hFFFFF, 1'b1, 1, "R8");
    pushWord(20'h55555, 1'b0, 1, "R8");
    drain(1, 1'b0, "R8");
    // R9 underrun then late word
    for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b0, 1'b1, "R9");
    pushWord(20'h9E371, 1'b0, 1, "R9");
    drain(1, 1'b0, "R9");

    // R11 sweep: 2048 patterns streamed gaplessly
    for (int p = 0; p < 2048; p++) begin
      logic [10:0] pv = p[10:0];
      pushWord({pv, pv[8:0]}, pv[0] ^ pv[5], 1, "R11");
    end
    drain(1, 1'b0, "R11");

    // R2 random handshake, strobes and invert traffic
    for (int i = 0; i < 4000; i++) begin
      lfsr = nextRand(lfsr);
      cyc(lfsr[3] & lfsr[7], {lfsr[19:0]} ^ {lfsr[31:12]}, lfsr[11],
          lfsr[5] | lfsr[9], "R2");
    end
    drain(1, 1'b0, "R2");
    cyc(1'b0, '0, 1'b0, 1'b0, "R3");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule